// File: doc/BRIEF.md
# Key-Protected Sequence Table

This block stores the instruction sequences that a serial-memory command sequencer runs. The table holds 32 sequences of four 32-bit words each, which is 128 words in all. Software reaches the table through a simple register bus with byte offsets. The sequencer reads any word through a separate read port, selected by a sequence number and a word number.

Software cannot change the table while it is locked. To change the lock state, software first writes a magic value to a key register. The very next bus write must then go to the lock-control register and carry a lock or unlock command. Any other write in between cancels the key. After reset the table is locked and sequence 0 holds a basic single-line read sequence.

Top module: `seqtab_regs`

## Requirements
- R1: After reset the table is locked and no key is armed. Sequence 0 holds word 0 = 0x08180403 (opcode 0x03 on one line, then a 24-bit address) and word 1 = 0x00002404 (read, then stop). Every other word is zero.
- R2: A bus read at offset 0x200 + 16·s + 4·w returns word w of sequence s. The sequencer port with seq_idx = s and seq_word = w returns the same word in the same cycle. This covers sequence 31, word 3 at offset 0x3FC.
- R3: While the table is unlocked, a bus write to a table offset replaces that word, and the new value is visible from the next cycle.
- R4: While the table is locked, bus writes to table offsets leave the table unchanged.
- R5: Writing 0x5AF05AF0 to the key register (offset 0x18) arms the key. If the next bus write goes to the lock-control register (offset 0x1C), value 0x1 locks the table and value 0x2 unlocks it.
- R6: A write to the lock-control register when no key is armed leaves the lock state unchanged.
- R7: When the key is armed, any bus write that is not to the lock-control register disarms it. This includes a write of any other value to the key register. A command written afterwards has no effect.
- R8: When the key is armed, a lock-control write whose value is neither 0x1 nor 0x2 leaves the lock state unchanged and uses up the key.
- R9: A read of the lock-control offset returns 0x1 while the table is locked and 0x2 while it is unlocked. A read of the key offset returns zero.
- R10: Cycles without a bus write, including reads, do not disarm an armed key.
- R11: Reads at offsets outside the table, the key register and the lock-control register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current bus address |
| bus_addr | input | 12 | Byte offset of the access. Bits [1:0] are ignored. |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| seq_idx | input | 5 | Sequencer read: sequence number |
| seq_word | input | 2 | Sequencer read: word within the sequence |
| seq_data | output | 32 | Sequencer read data, combinational |

## Verification
The assertions check the following on every cycle:
- The lock state moves only in the cycle after an armed key meets a lock-control write.
- Any other write disarms the key, and idle cycles keep it armed.
- An invalid command does not move the lock state.
- When the word under the sequencer port is written, the port shows the new value if the table is unlocked and the old value if it is locked.

The bench scenarios are needed for the rest:
- the exact reset contents of sequence 0;
- that bus reads and the sequencer port return the same word at the far end of the table;
- longer orderings, such as key, wrong key, command, or key, invalid command, valid command;
- the zero returned from unmapped offsets.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;
  localparam logic [31:0] KEY_MAGIC  = 32'h5AF0_5AF0;
  localparam logic [31:0] CMD_LOCK   = 32'h0000_0001;
  localparam logic [31:0] CMD_UNLOCK = 32'h0000_0002;

  // Sequence entry field codes: {instr[5:0], lines[1:0], operand[7:0]} per half.
  localparam logic [5:0] OP_STOP = 6'h00;
  localparam logic [5:0] OP_CMD  = 6'h01;
  localparam logic [5:0] OP_ADDR = 6'h02;
  localparam logic [5:0] OP_READ = 6'h09;

  typedef enum logic {KEY_IDLE = 1'b0, KEY_ARMED = 1'b1} key_state_t;

  function automatic logic [15:0] seq_half(logic [5:0] op, logic [1:0] lines,
                                           logic [7:0] opr);
    return {op, lines, opr};
  endfunction

  // Reset content of the flat word index g (sequence 0 carries a basic read).
  function automatic logic [31:0] dflt_word(int g);
    case (g)
      0:       return {seq_half(OP_ADDR, 2'd0, 8'd24), seq_half(OP_CMD, 2'd0, 8'h03)};
      1:       return {seq_half(OP_STOP, 2'd0, 8'd0),  seq_half(OP_READ, 2'd0, 8'h04)};
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/seqtab_lock.sv
module seqtab_lock
  import seqtab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              key_hit,
  input  logic              ctl_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              armed
);
  key_state_t key_q, key_d;
  logic       lock_q, lock_d;

  always_comb begin
    key_d  = key_q;
    lock_d = lock_q;
    if (wr_en) begin
      key_d = (key_hit && (wdata == DATA_W'(KEY_MAGIC))) ? KEY_ARMED : KEY_IDLE;
      if (ctl_hit && (key_q == KEY_ARMED)) begin
        if (wdata == DATA_W'(CMD_LOCK))        lock_d = 1'b1;
        else if (wdata == DATA_W'(CMD_UNLOCK)) lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= KEY_IDLE;
      lock_q <= 1'b1;
    end else begin
      key_q  <= key_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
  assign armed  = (key_q == KEY_ARMED);
endmodule

// File: rtl/seqtab_store.sv
module seqtab_store
  import seqtab_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORDS = 128,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [DATA_W-1:0] rda_data,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [DATA_W-1:0] rdb_data
);
  logic [DATA_W-1:0] mem [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic we;
    assign we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem[g] <= DATA_W'(dflt_word(g));
      else if (we) mem[g] <= wdata;
    end
  end

  assign rda_data = mem[rda_idx];
  assign rdb_data = mem[rdb_idx];
endmodule

// File: rtl/seqtab_regs.sv
module seqtab_regs
  import seqtab_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 32,
  parameter int              NUM_SEQ    = 32,
  parameter int              SEQ_WORDS  = 4,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] KEY_OFF    = 12'h018,
  parameter logic [ADDR_W-1:0] CTL_OFF    = 12'h01C,
  localparam int SEQ_W  = $clog2(NUM_SEQ),
  localparam int WSEL_W = $clog2(SEQ_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SEQ_W-1:0]  seq_idx,
  input  logic [WSEL_W-1:0] seq_word,
  output logic [DATA_W-1:0] seq_data
);
  localparam int NWORDS = NUM_SEQ * SEQ_WORDS;
  localparam int WIDX_W = $clog2(NWORDS);
  localparam int BSH    = 2;
  localparam logic [ADDR_W:0] TBL_END = (ADDR_W+1)'(TABLE_BASE) + (ADDR_W+1)'(NWORDS * 4);

  logic              tbl_hit, key_hit, ctl_hit;
  logic [ADDR_W-1:0] tbl_off;
  logic [WIDX_W-1:0] bus_widx, seq_widx;
  logic [DATA_W-1:0] tbl_rdata;
  logic              lock_state, key_armed, tbl_we;

  assign tbl_off  = bus_addr - TABLE_BASE;
  assign tbl_hit  = (bus_addr >= TABLE_BASE) && ({1'b0, bus_addr} < TBL_END);
  assign key_hit  = bus_addr[ADDR_W-1:BSH] == KEY_OFF[ADDR_W-1:BSH];
  assign ctl_hit  = bus_addr[ADDR_W-1:BSH] == CTL_OFF[ADDR_W-1:BSH];
  assign bus_widx = tbl_off[BSH +: WIDX_W];
  // SEQ_WORDS is a power of two, so the flat index is a concatenation.
  assign seq_widx = {seq_idx, seq_word};
  assign tbl_we   = bus_wr && tbl_hit && !lock_state;

  seqtab_lock #(.DATA_W(DATA_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .key_hit (key_hit),
    .ctl_hit (ctl_hit),
    .wdata   (bus_wdata),
    .locked  (lock_state),
    .armed   (key_armed)
  );

  seqtab_store #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (bus_widx),
    .wdata    (bus_wdata),
    .rda_idx  (bus_widx),
    .rda_data (tbl_rdata),
    .rdb_idx  (seq_widx),
    .rdb_data (seq_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (tbl_hit)      bus_rdata = tbl_rdata;
    else if (ctl_hit) bus_rdata = lock_state ? DATA_W'(CMD_LOCK) : DATA_W'(CMD_UNLOCK);
  end
endmodule

// File: rtl/seqtab_chk.sv
module seqtab_chk
  import seqtab_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                SEQ_W      = 5,
  parameter int                WSEL_W     = 2,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] KEY_OFF    = 12'h018,
  parameter logic [ADDR_W-1:0] CTL_OFF    = 12'h01C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [SEQ_W-1:0]  seq_idx,
  input logic [WSEL_W-1:0] seq_word,
  input logic [DATA_W-1:0] seq_data,
  input logic              locked,
  input logic              armed
);
  logic              is_ctl, is_key_ok, port_hit, port_same;
  logic [ADDR_W-1:0] port_addr;

  assign is_ctl    = bus_addr[ADDR_W-1:2] == CTL_OFF[ADDR_W-1:2];
  assign is_key_ok = (bus_addr[ADDR_W-1:2] == KEY_OFF[ADDR_W-1:2]) &&
                     (bus_wdata == DATA_W'(KEY_MAGIC));
  assign port_addr = TABLE_BASE + (ADDR_W'({seq_idx, seq_word}) << 2);
  assign port_hit  = bus_addr[ADDR_W-1:2] == port_addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_same <= 1'b0;
    else        port_same <= 1'b1;
  end

  // R5 R6: the lock state moves only after an armed key meets a control write.
  p_lock_needs_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && bus_wr && is_ctl) |=> $stable(locked));

  // R7: any write other than a control write drops the key, unless it re-arms it.
  p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr && !is_ctl && !is_key_ok) |=> !armed);

  // R10: cycles without a write keep the key armed.
  p_read_keeps_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !bus_wr) |=> armed);

  // R8: an invalid command does not change the lock state.
  p_bad_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr && is_ctl && bus_wdata != DATA_W'(CMD_LOCK) &&
     bus_wdata != DATA_W'(CMD_UNLOCK)) |=> $stable(locked));

  // R4: a locked write to the word under the sequencer port leaves it unchanged.
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_same && locked && bus_wr && port_hit) |=>
      (!($stable(seq_idx) && $stable(seq_word)) || $stable(seq_data)));

  // R3: an unlocked write to that word shows up on the sequencer port.
  p_unlocked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_same && !locked && bus_wr && port_hit) |=>
      (!($stable(seq_idx) && $stable(seq_word)) || (seq_data == $past(bus_wdata))));
endmodule

bind seqtab_regs seqtab_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .WSEL_W(WSEL_W),
  .TABLE_BASE(TABLE_BASE), .KEY_OFF(KEY_OFF), .CTL_OFF(CTL_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .seq_idx(seq_idx), .seq_word(seq_word),
  .seq_data(seq_data), .locked(lock_state), .armed(key_armed)
);

// File: tb/sim_seqtab_regs.sv
module sim_seqtab_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, seq_data;
  logic [4:0]  seq_idx;
  logic [1:0]  seq_word;

  int tests = 0;
  int fails = 0;

  // Behavioural reference model.
  int unsigned m_mem [128];
  bit m_locked, m_armed;

  seqtab_regs u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void m_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_mem[0] = 32'h08180403;
    m_mem[1] = 32'h00002404;
    m_locked = 1'b1;
    m_armed  = 1'b0;
  endfunction

  function automatic int unsigned m_read(int unsigned a);
    if (a >= 32'h200 && a < 32'h400) return m_mem[(a - 32'h200) >> 2];
    if ((a >> 2) == (32'h1C >> 2))   return m_locked ? 1 : 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else if (bus_wr) begin
      int unsigned a;
      bit was_armed;
      a = int'(bus_addr);
      was_armed = m_armed;
      m_armed = ((a >> 2) == (32'h18 >> 2)) && (bus_wdata == 32'h5AF05AF0);
      if (was_armed && (a >> 2) == (32'h1C >> 2)) begin
        if (bus_wdata == 1) m_locked = 1'b1;
        else if (bus_wdata == 2) m_locked = 1'b0;
      end
      if (a >= 32'h200 && a < 32'h400 && !m_locked) m_mem[(a - 32'h200) >> 2] = bus_wdata;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      tests++;
      if (bus_rdata !== m_read(int'(bus_addr))) begin
        fails++;
        $display("FAIL R2 model rdata @%h: got %h exp %h", bus_addr, bus_rdata, m_read(int'(bus_addr)));
      end
      tests++;
      if (seq_data !== m_mem[{seq_idx, seq_word}]) begin
        fails++;
        $display("FAIL R2 model seq_data [%0d:%0d]: got %h exp %h", seq_idx, seq_word, seq_data, m_mem[{seq_idx, seq_word}]);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #2;
    tests++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h: got %h exp %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_seq(input logic [4:0] s, input logic [1:0] w, input logic [31:0] exp, input string req);
    @(negedge clk);
    seq_idx = s; seq_word = w;
    #2;
    tests++;
    if (seq_data !== exp) begin
      fails++;
      $display("FAIL %s seq port %0d/%0d: got %h exp %h", req, s, w, seq_data, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    seq_idx = '0; seq_word = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents and lock state
    chk_rd(12'h200, 32'h08180403, "R1");
    chk_rd(12'h204, 32'h00002404, "R1");
    chk_rd(12'h210, 32'h0, "R1");
    chk_rd(12'h01C, 32'h1, "R1");
    chk_rd(12'h018, 32'h0, "R9");
    // R4 locked writes ignored
    wr(12'h210, 32'hA5A5A5A5);
    chk_rd(12'h210, 32'h0, "R4");
    // R6 command without key
    wr(12'h01C, 32'h2);
    chk_rd(12'h01C, 32'h1, "R6");
    // R5 unlock
    wr(12'h018, 32'h5AF05AF0);
    wr(12'h01C, 32'h2);
    chk_rd(12'h01C, 32'h2, "R5");
    // R3 R2 writes and both read paths
    wr(12'h210, 32'h11112222);
    chk_rd(12'h210, 32'h11112222, "R3");
    chk_seq(5'd1, 2'd0, 32'h11112222, "R2");
    wr(12'h3FC, 32'hCAFEF00D);
    chk_rd(12'h3FC, 32'hCAFEF00D, "R2");
    chk_seq(5'd31, 2'd3, 32'hCAFEF00D, "R2");
    // R7 intervening write cancels the key
    wr(12'h018, 32'h5AF05AF0);
    wr(12'h214, 32'h33334444);
    wr(12'h01C, 32'h1);
    chk_rd(12'h01C, 32'h2, "R7");
    chk_rd(12'h214, 32'h33334444, "R7");
    // R7 wrong key value cancels
    wr(12'h018, 32'h5AF05AF0);
    wr(12'h018, 32'h12345678);
    wr(12'h01C, 32'h1);
    chk_rd(12'h01C, 32'h2, "R7");
    // R8 invalid command consumes the key
    wr(12'h018, 32'h5AF05AF0);
    wr(12'h01C, 32'h3);
    chk_rd(12'h01C, 32'h2, "R8");
    wr(12'h01C, 32'h1);
    chk_rd(12'h01C, 32'h2, "R8");
    // R10 reads keep the key armed, then R5 lock
    wr(12'h018, 32'h5AF05AF0);
    chk_rd(12'h200, 32'h08180403, "R10");
    chk_rd(12'h3FC, 32'hCAFEF00D, "R10");
    wr(12'h01C, 32'h1);
    chk_rd(12'h01C, 32'h1, "R10");
    // R4 locked again
    wr(12'h200, 32'hDEADBEEF);
    chk_rd(12'h200, 32'h08180403, "R4");
    chk_seq(5'd0, 2'd1, 32'h00002404, "R4");
    // R11 unmapped offsets
    chk_rd(12'h100, 32'h0, "R11");
    chk_rd(12'h400, 32'h0, "R11");
    chk_rd(12'h014, 32'h0, "R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule